// File: doc/BRIEF.md
# Multi-Core Debug Halt Cross-Trigger Network

This block couples the debug-halt behaviour of several processor cores. Every core reports whether it is in debug mode, emits a one-cycle break pulse when it halts, and emits a one-cycle trace trigger. The network turns these signals into three per-core inputs: a latched break request, a level run-stall and a trace trigger pulse. A core never drives any of its own inputs.

Each core has a four-bit link setting. The setting chooses whether the core sends breaks, accepts breaks, drives stalls with its debug-mode level, and accepts stalls. Two coupling styles are available, and either can be chosen for each core. A break forces the other cores into debug mode. A stall only freezes execution: it holds while the stalling core stays halted and it is lifted while the stalled core is itself in debug mode. Trace triggers use the same links as breaks but go to a separate output, so they never halt or stall a core.

Writing zero to a core's setting detaches that core from the network, for example while it steps or prepares to resume. The saved value can then be written back. All outputs are registered, so an event on one core reaches the other cores one clock later.

Top module: `halt_xnet`

## Requirements
- R1: After reset every link setting reads 0, and `brk_req`, `run_stall` and `trig_in` are all 0.
- R2: The link setting has four bits: [0] accept break, [1] send break, [2] accept stall, [3] send debug level. A write with `cfg_we` high stores `cfg_wdata` for core `cfg_addr` at the clock edge. `cfg_rdata` always shows the stored setting of core `cfg_addr`.
- R3: Suppose `core_brk_out[i]` is high and core i has send-break set. Then `brk_req[j]` goes high one cycle later for every other core j that has accept-break set. Other cores stay low.
- R4: `brk_req[j]` stays high until a cycle in which `core_dbg_mode[j]` is high, and it is low in the cycle after that.
- R5: A core's own `core_brk_out` never sets its own `brk_req`, and its own `core_dbg_mode` never raises its own `run_stall`.
- R6: One cycle after any other core i is in debug mode with send-debug set, `run_stall[j]` is high, provided core j has accept-stall set and is not in debug mode.
- R7: `run_stall[j]` drops one cycle after the last stalling core leaves debug mode.
- R8: `run_stall[j]` is low in the cycle after any cycle in which core j is itself in debug mode.
- R9: `core_trig_out` uses the same send-break and accept-break bits as breaks. It gives a one-cycle `trig_in` pulse one cycle later and never changes `brk_req` or `run_stall`.
- R10: While a core's setting is 0, its break pulses set no `brk_req` anywhere. After the saved setting is written back, its breaks route again.
- R11: With the break-only setting (4'b0011) on all cores, `run_stall` stays 0 whatever the debug levels are. A latched `brk_req` also stays set when the core that sent the break leaves debug mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Link setting write strobe |
| cfg_addr | input | IDX_W | Core index for read and write |
| cfg_wdata | input | 4 | Link setting to store |
| cfg_rdata | output | 4 | Stored link setting of `cfg_addr` |
| core_dbg_mode | input | N | Debug-mode level of each core |
| core_brk_out | input | N | Break pulse of each core |
| core_trig_out | input | N | Trace trigger pulse of each core |
| brk_req | output | N | Latched break request to each core |
| run_stall | output | N | Run-stall level to each core |
| trig_in | output | N | Trace trigger pulse to each core |

## Verification
The hardest situation to reach is a stalled core that enters debug mode while another core is still stalling it. The stall must lift only for the duration of that debug visit and come back when the visit ends. The bench gets there in three steps. It holds one core in debug mode so that all others stall. It then raises a second core's debug level, checks that both halted cores are released while the rest stay stalled, and drops it again to watch the stall return. The latched break gets the same treatment: a single-cycle pulse is followed by many idle cycles before the target acknowledges.

// File: rtl/halt_xnet_pkg.sv
package halt_xnet_pkg;

  // Link setting; bit positions are part of the register interface.
  typedef struct packed {
    logic dbg_out_en;   // [3] send debug level
    logic stall_in_en;  // [2] accept stall
    logic brk_out_en;   // [1] send break
    logic brk_in_en;    // [0] accept break
  } link_cfg_t;

  localparam int unsigned LINK_W = $bits(link_cfg_t);

  // True when any source other than 'self' is active (sources limited to 32).
  function automatic logic others_any(input logic [31:0] src,
                                      input int unsigned n,
                                      input int unsigned self);
    logic hit;
    hit = 1'b0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i < n && i != self && src[i]) hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/halt_xnet_cfg.sv
module halt_xnet_cfg
  import halt_xnet_pkg::*;
#(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_addr,
  input  logic [LINK_W-1:0] cfg_wdata,
  output logic [LINK_W-1:0] cfg_rdata,
  output logic [N-1:0]      brk_in_en,
  output logic [N-1:0]      brk_out_en,
  output logic [N-1:0]      stall_in_en,
  output logic [N-1:0]      dbg_out_en
);
  link_cfg_t cfg_q [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) cfg_q[i] <= '0;
    end else if (cfg_we && (int'(cfg_addr) < N)) begin
      cfg_q[cfg_addr] <= link_cfg_t'(cfg_wdata);
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (int'(cfg_addr) < N) cfg_rdata = cfg_q[cfg_addr];
  end

  for (genvar g = 0; g < N; g++) begin : g_fan
    assign brk_in_en[g]   = cfg_q[g].brk_in_en;
    assign brk_out_en[g]  = cfg_q[g].brk_out_en;
    assign stall_in_en[g] = cfg_q[g].stall_in_en;
    assign dbg_out_en[g]  = cfg_q[g].dbg_out_en;
  end
endmodule

// File: rtl/halt_xnet_route.sv
module halt_xnet_route
  import halt_xnet_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] core_dbg_mode,
  input  logic [N-1:0] core_brk_out,
  input  logic [N-1:0] core_trig_out,
  input  logic [N-1:0] brk_in_en,
  input  logic [N-1:0] brk_out_en,
  input  logic [N-1:0] stall_in_en,
  input  logic [N-1:0] dbg_out_en,
  output logic [N-1:0] brk_hit,
  output logic [N-1:0] stall_hit,
  output logic [N-1:0] trig_hit
);
  logic [31:0] brk_src, dbg_src, trig_src;

  assign brk_src  = 32'(core_brk_out & brk_out_en);
  assign dbg_src  = 32'(core_dbg_mode & dbg_out_en);
  assign trig_src = 32'(core_trig_out & brk_out_en);

  for (genvar j = 0; j < N; j++) begin : g_dst
    assign brk_hit[j]   = brk_in_en[j] & others_any(brk_src, N, j);
    assign stall_hit[j] = stall_in_en[j] & ~core_dbg_mode[j]
                          & others_any(dbg_src, N, j);
    assign trig_hit[j]  = brk_in_en[j] & others_any(trig_src, N, j);
  end
endmodule

// File: rtl/halt_xnet_outreg.sv
module halt_xnet_outreg #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] core_dbg_mode,
  input  logic [N-1:0] brk_hit,
  input  logic [N-1:0] stall_hit,
  input  logic [N-1:0] trig_hit,
  output logic [N-1:0] brk_req,
  output logic [N-1:0] run_stall,
  output logic [N-1:0] trig_in
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_req   <= '0;
      run_stall <= '0;
      trig_in   <= '0;
    end else begin
      // entry into debug mode acknowledges and wins over a new break
      brk_req   <= (brk_req | brk_hit) & ~core_dbg_mode;
      run_stall <= stall_hit;
      trig_in   <= trig_hit;
    end
  end
endmodule

// File: rtl/halt_xnet.sv
module halt_xnet
  import halt_xnet_pkg::*;
#(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_addr,
  input  logic [3:0]        cfg_wdata,
  output logic [3:0]        cfg_rdata,
  input  logic [N-1:0]      core_dbg_mode,
  input  logic [N-1:0]      core_brk_out,
  input  logic [N-1:0]      core_trig_out,
  output logic [N-1:0]      brk_req,
  output logic [N-1:0]      run_stall,
  output logic [N-1:0]      trig_in
);
  logic [N-1:0] brk_in_en, brk_out_en, stall_in_en, dbg_out_en;
  logic [N-1:0] brk_hit, stall_hit, trig_hit;

  halt_xnet_cfg #(.N(N), .IDX_W(IDX_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .brk_in_en(brk_in_en), .brk_out_en(brk_out_en),
    .stall_in_en(stall_in_en), .dbg_out_en(dbg_out_en)
  );

  halt_xnet_route #(.N(N)) route_i (
    .core_dbg_mode(core_dbg_mode), .core_brk_out(core_brk_out),
    .core_trig_out(core_trig_out),
    .brk_in_en(brk_in_en), .brk_out_en(brk_out_en),
    .stall_in_en(stall_in_en), .dbg_out_en(dbg_out_en),
    .brk_hit(brk_hit), .stall_hit(stall_hit), .trig_hit(trig_hit)
  );

  halt_xnet_outreg #(.N(N)) out_i (
    .clk(clk), .rst_n(rst_n), .core_dbg_mode(core_dbg_mode),
    .brk_hit(brk_hit), .stall_hit(stall_hit), .trig_hit(trig_hit),
    .brk_req(brk_req), .run_stall(run_stall), .trig_in(trig_in)
  );
endmodule

// File: rtl/halt_xnet_chk.sv
module halt_xnet_chk #(
  parameter int unsigned N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] core_dbg_mode,
  input logic [N-1:0] core_brk_out,
  input logic [N-1:0] core_trig_out,
  input logic [N-1:0] brk_req,
  input logic [N-1:0] run_stall,
  input logic [N-1:0] trig_in,
  input logic [N-1:0] brk_hit,
  input logic [N-1:0] stall_hit
);
  for (genvar j = 0; j < N; j++) begin : g_core
    localparam logic [N-1:0] SELF = {{(N-1){1'b0}}, 1'b1} << j;

    assert_brk_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_hit[j] && !core_dbg_mode[j]) |=> brk_req[j]);

    assert_brk_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_req[j] && !core_dbg_mode[j]) |=> brk_req[j]);

    assert_brk_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      core_dbg_mode[j] |=> !brk_req[j]);

    assert_no_self_brk_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (((core_brk_out & ~SELF) == '0) && !brk_req[j]) |=> !brk_req[j]);

    assert_stall_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stall_hit[j] |=> run_stall[j]);

    assert_stall_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !stall_hit[j] |=> !run_stall[j]);

    assert_stall_lift_R8: assert property (@(posedge clk) disable iff (!rst_n)
      core_dbg_mode[j] |=> !run_stall[j]);
  end

  assert_trig_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_trig_out == '0) |=> (trig_in == '0));
endmodule

bind halt_xnet halt_xnet_chk #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .core_dbg_mode(core_dbg_mode),
  .core_brk_out(core_brk_out), .core_trig_out(core_trig_out),
  .brk_req(brk_req), .run_stall(run_stall), .trig_in(trig_in),
  .brk_hit(brk_hit), .stall_hit(stall_hit)
);

// File: tb/halt_xnet_tb_top.sv
module halt_xnet_tb_top;
  localparam int N = 4;
  localparam int IDX_W = 2;
  localparam time CLK_PERIOD = 10ns;

  localparam logic [3:0] LINK_NONE  = 4'b0000;
  localparam logic [3:0] LINK_BREAK = 4'b0011; // accept+send break
  localparam logic [3:0] LINK_STALL = 4'b1100; // accept stall + send level

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [IDX_W-1:0] cfg_addr = '0;
  logic [3:0] cfg_wdata = '0;
  logic [3:0] cfg_rdata;
  logic [N-1:0] core_dbg_mode = '0, core_brk_out = '0, core_trig_out = '0;
  logic [N-1:0] brk_req, run_stall, trig_in;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halt_xnet #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .core_dbg_mode(core_dbg_mode), .core_brk_out(core_brk_out),
    .core_trig_out(core_trig_out), .brk_req(brk_req),
    .run_stall(run_stall), .trig_in(trig_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_cfg(input int idx, input logic [3:0] v);
    cfg_we = 1'b1; cfg_addr = IDX_W'(idx); cfg_wdata = v;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic set_all(input logic [3:0] v);
    for (int i = 0; i < N; i++) wr_cfg(i, v);
  endtask

  task automatic rd_cfg(input int idx, output logic [3:0] v);
    cfg_addr = IDX_W'(idx);
    #1;
    v = cfg_rdata;
  endtask

  task automatic pulse_brk(input logic [N-1:0] v);
    core_brk_out = v;
    step();
    core_brk_out = '0;
  endtask

  task automatic flush();
    core_dbg_mode = '1;
    step();
    core_dbg_mode = '0;
    step();
  endtask

  task automatic t_reset();
    logic [3:0] v;
    chk("R1 brk_req", 32'(brk_req), 0);
    chk("R1 run_stall", 32'(run_stall), 0);
    chk("R1 trig_in", 32'(trig_in), 0);
    for (int i = 0; i < N; i++) begin
      rd_cfg(i, v);
      chk("R1 cfg", 32'(v), 0);
    end
  endtask

  task automatic t_cfg();
    logic [3:0] v;
    for (int i = 0; i < N; i++) wr_cfg(i, 4'(4'h5 + 3*i));
    for (int i = 0; i < N; i++) begin
      rd_cfg(i, v);
      chk("R2 readback", 32'(v), 32'(4'(4'h5 + 3*i)));
    end
    set_all(LINK_NONE);
  endtask

  task automatic t_break();
    set_all(LINK_BREAK);
    pulse_brk(4'b0001);
    chk("R3 break fanout", 32'(brk_req), 32'h0E);
    chk("R5 no self break", 32'(brk_req[0]), 0);
    repeat (6) step();
    chk("R4 sticky after idle", 32'(brk_req), 32'h0E);
    core_dbg_mode = 4'b0001;    // source halted
    step();
    core_dbg_mode = 4'b0000;    // source leaves debug
    step();
    chk("R11 break survives source resume", 32'(brk_req), 32'h0E);
    chk("R11 no stall in break mode", 32'(run_stall), 0);
    core_dbg_mode = 4'b0010;    // core 1 acknowledges
    step();
    chk("R4 ack clears", 32'(brk_req), 32'h0C);
    core_dbg_mode = 4'b1111;
    step();
    chk("R11 no stall all halted", 32'(run_stall), 0);
    core_dbg_mode = '0;
    step();
  endtask

  task automatic t_partial();
    set_all(LINK_BREAK);
    wr_cfg(2, 4'b0010);          // core 2 sends only
    pulse_brk(4'b1000);
    chk("R3 masked receiver", 32'(brk_req), 32'h03);
    flush();
    wr_cfg(3, 4'b0001);          // core 3 receives only
    pulse_brk(4'b1000);
    chk("R3 sender disabled", 32'(brk_req), 0);
    flush();
  endtask

  task automatic t_stall();
    set_all(LINK_STALL);
    core_dbg_mode = 4'b0010;
    step();
    chk("R6 stall others", 32'(run_stall), 32'h0D);
    chk("R5 no self stall", 32'(run_stall[1]), 0);
    core_dbg_mode = 4'b0110;
    step();
    chk("R8 stalled core in debug lifts", 32'(run_stall), 32'h09);
    core_dbg_mode = 4'b0010;
    step();
    chk("R8 stall returns", 32'(run_stall), 32'h0D);
    chk("R6 stall gives no break", 32'(brk_req), 0);
    core_dbg_mode = 4'b0000;
    step();
    chk("R7 release", 32'(run_stall), 0);
    wr_cfg(0, 4'b0100);          // core 0 accepts but cannot send
    core_dbg_mode = 4'b0001;
    step();
    chk("R6 send disabled", 32'(run_stall), 0);
    core_dbg_mode = '0;
    step();
  endtask

  task automatic t_trace();
    set_all(LINK_BREAK);
    core_trig_out = 4'b0100;
    step();
    core_trig_out = '0;
    chk("R9 trig fanout", 32'(trig_in), 32'h0B);
    chk("R9 trig no break", 32'(brk_req), 0);
    chk("R9 trig no stall", 32'(run_stall), 0);
    step();
    chk("R9 trig one cycle", 32'(trig_in), 0);
  endtask

  task automatic t_disconnect();
    logic [3:0] saved;
    set_all(LINK_BREAK);
    rd_cfg(0, saved);
    wr_cfg(0, 4'b0000);
    pulse_brk(4'b0001);
    chk("R10 detached", 32'(brk_req), 0);
    step();
    chk("R10 detached later", 32'(brk_req), 0);
    wr_cfg(0, saved);
    pulse_brk(4'b0001);
    chk("R10 restored", 32'(brk_req), 32'h0E);
    flush();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_cfg();
    t_break();
    t_partial();
    t_stall();
    t_trace();
    t_disconnect();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule